// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

After reset this block waits a long power-up pause, then sends a frequency synthesizer the fixed list of serial words it needs once, by instructing a separate serial transmitter. The transmitter does the bit timing. This block only says which word to send next, how long that word is, and whether the word is framed by a low enable. It then waits for the transmitter to report that the word has gone out. The synthesizer decides which register a word targets purely from the number of bits in the word, so each word length is fixed by the sequence.

The list has five entries:
- A reset preamble: four bare clocks, sent with data low and enable held high.
- A framed 5-bit word with value 2, which completes that reset.
- An 8-bit all-zero configuration word.
- A 15-bit reference-divider word.
- A 16-bit feedback-divider word.

The synthesizer output equals the reference clock divided by the reference divider and multiplied by the feedback divider. The defaults are 80 and 2140. With a 4 MHz reference these give a 50 kHz step and a 107 MHz output. Both dividers are parameters.

Once the last word is acknowledged, the block raises a done flag and stays idle until the next reset.

The controller has four states:

| State | Meaning |
|---|---|
| ST_POWERUP | waiting for the start-up timer |
| ST_ISSUE | one cycle with the start pulse high |
| ST_WAIT | waiting for the transmitter's acknowledge |
| ST_FINISHED | terminal state |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| T_DELAY_OVER | ST_POWERUP | ST_ISSUE | the timer has expired |
| T_LAUNCHED | ST_ISSUE | ST_WAIT | always |
| T_NEXT_WORD | ST_WAIT | ST_ISSUE | acknowledge for a word that is not the last; the word index increments |
| T_LAST_ACK | ST_WAIT | ST_FINISHED | acknowledge for the last word |

Top module: `synth_prog_seq`

## Requirements
- R1: While `rst_n` is low, `xfer_start` and `seq_done` are 0.
- R2: `xfer_start` stays 0 for the first `STARTUP_CYCLES` rising edges after reset release. It is first high in the cycle that follows rising edge `STARTUP_CYCLES`+1.
- R3: The first transfer is the preamble: `xfer_len`=4, `xfer_data`=0, `xfer_framed`=0 (bare clocks, enable held high).
- R4: The second transfer has `xfer_len`=5, `xfer_data`=2 and `xfer_framed`=1.
- R5: The third transfer has `xfer_len`=8, `xfer_data`=0 and `xfer_framed`=1.
- R6: The fourth transfer has `xfer_len`=15, `xfer_data`=`REF_DIV` (default 80) and `xfer_framed`=1.
- R7: The fifth transfer has `xfer_len`=16, `xfer_data`=`FB_DIV` (default 2140) and `xfer_framed`=1.
- R8: `xfer_start` is a one-cycle pulse. A new word starts only after the previous one is acknowledged, in the cycle right after the cycle in which `xfer_done` was high.
- R9: `xfer_len`, `xfer_data` and `xfer_framed` stay unchanged from a start pulse until that word's acknowledge.
- R10: `xfer_done` has no effect outside the waiting state, that is, during the power-up pause or in the start-pulse cycle itself.
- R11: In the cycle after the fifth acknowledge, `seq_done` goes to 1 and stays 1. No further start pulse follows.
- R12: A reset in the middle of the sequence returns the block to the power-up pause, and the full sequence is then sent again from the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| xfer_done | input | 1 | transmitter acknowledge, one cycle, for the word in flight |
| xfer_start | output | 1 | one-cycle request to send the presented word |
| xfer_framed | output | 1 | 1: frame the word with enable low; 0: bare clocks with enable high |
| xfer_len | output | 5 | number of bits to send, MSB first |
| xfer_data | output | 16 | word value, right-aligned |
| seq_done | output | 1 | set once the whole list has been acknowledged |

## Verification
The acknowledge input can arrive in the same cycle as the start pulse for a new word. The bench provokes this by raising `xfer_done` in the very cycle `xfer_start` is seen for the third word. It judges the outcome by requiring that no new start appears until the real, delayed acknowledge, and that the following word is still the fourth in the list. A stray acknowledge in the middle of the power-up pause is judged the same way, through the exact cycle of the first start.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    localparam int NUM_WORDS = 5;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int LEN_W     = 5;
    localparam int DATA_W    = 16;

    typedef enum logic [1:0] {
        ST_POWERUP,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISHED
    } seq_state_t;

    typedef struct packed {
        logic              framed;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } word_t;
endpackage

// File: rtl/synth_prog_delay.sv
module synth_prog_delay #(
    parameter int unsigned CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIMIT);

    AST_DELAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired); // R2
endmodule

// File: rtl/synth_prog_words.sv
module synth_prog_words
    import synth_prog_pkg::*;
#(
    parameter int unsigned REF_DIV = 80,
    parameter int unsigned FB_DIV  = 2140
) (
    input  logic [IDX_W-1:0] idx,
    output word_t            word
);
    localparam logic [DATA_W-1:0] REF_VAL = DATA_W'(REF_DIV);
    localparam logic [DATA_W-1:0] FB_VAL  = DATA_W'(FB_DIV);

    initial begin
        AST_REF_FITS: assert (REF_DIV < 32768) else $error("reference divider exceeds 15 bits"); // R6
        AST_FB_FITS:  assert (FB_DIV < 65536) else $error("feedback divider exceeds 16 bits"); // R7
    end

    always_comb begin
        word = '0;
        unique case (idx)
            IDX_W'(0): word = '{framed: 1'b0, len: LEN_W'(4),  data: '0};
            IDX_W'(1): word = '{framed: 1'b1, len: LEN_W'(5),  data: DATA_W'(2)};
            IDX_W'(2): word = '{framed: 1'b1, len: LEN_W'(8),  data: '0};
            IDX_W'(3): word = '{framed: 1'b1, len: LEN_W'(15), data: REF_VAL};
            IDX_W'(4): word = '{framed: 1'b1, len: LEN_W'(16), data: FB_VAL};
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/synth_prog_fsm.sv
module synth_prog_fsm
    import synth_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             delay_expired,
    input  logic             xfer_done,
    output logic [IDX_W-1:0] word_idx,
    output logic             xfer_start,
    output logic             seq_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // next-state and transition logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_POWERUP: begin
                if (delay_expired) state_d = ST_ISSUE;          // T_DELAY_OVER
            end
            ST_ISSUE: begin
                state_d = ST_WAIT;                              // T_LAUNCHED
            end
            ST_WAIT: begin
                if (xfer_done) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_FINISHED;                  // T_LAST_ACK
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = ST_ISSUE;                     // T_NEXT_WORD
                    end
                end
            end
            ST_FINISHED: begin
                state_d = ST_FINISHED;
            end
            default: state_d = ST_POWERUP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWERUP;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        xfer_start = 1'b0;
        seq_done   = 1'b0;
        unique case (state_q)
            ST_POWERUP:  ;
            ST_ISSUE:    xfer_start = 1'b1;
            ST_WAIT:     ;
            ST_FINISHED: seq_done = 1'b1;
            default:     ;
        endcase
    end

    assign word_idx = idx_q;

    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        !delay_expired |-> !xfer_start); // R2
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R8
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        word_idx <= LAST_IDX); // R7
    AST_ISSUE_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && xfer_done) |=> (state_q == ST_WAIT && $stable(idx_q))); // R10
    AST_FINISHED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (seq_done && !xfer_start)); // R11
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
    import synth_prog_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES = 2000000,
    parameter int unsigned REF_DIV        = 80,
    parameter int unsigned FB_DIV         = 2140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_done,
    output logic              xfer_start,
    output logic              xfer_framed,
    output logic [LEN_W-1:0]  xfer_len,
    output logic [DATA_W-1:0] xfer_data,
    output logic              seq_done
);
    logic             delay_expired;
    logic [IDX_W-1:0] word_idx;
    word_t            cur_word;

    synth_prog_delay #(.CYCLES(STARTUP_CYCLES)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .expired (delay_expired)
    );

    synth_prog_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .delay_expired (delay_expired),
        .xfer_done     (xfer_done),
        .word_idx      (word_idx),
        .xfer_start    (xfer_start),
        .seq_done      (seq_done)
    );

    synth_prog_words #(.REF_DIV(REF_DIV), .FB_DIV(FB_DIV)) u_words (
        .idx  (word_idx),
        .word (cur_word)
    );

    assign xfer_framed = cur_word.framed;
    assign xfer_len    = cur_word.len;
    assign xfer_data   = cur_word.data;

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || (!xfer_done && !seq_done && $past(xfer_start)))
        |=> $stable({xfer_framed, xfer_len, xfer_data})); // R9
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (xfer_len >= LEN_W'(4) && xfer_len <= LEN_W'(16))); // R3
endmodule

// File: tb/synth_prog_seq_test.sv
module synth_prog_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int STARTUP    = 300;
    localparam int REF_D      = 80;
    localparam int FB_D       = 2140;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_start, xfer_framed, seq_done;
    logic [4:0]  xfer_len;
    logic [15:0] xfer_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [21:0] exp_q[$];
    int  lat_tab[5] = '{1, 3, 4, 2, 5};
    string req_tab[5] = '{"R3", "R4", "R5", "R6", "R7"};

    int  words_seen, done_count, last_done_cyc, countdown;
    bit  outstanding, held_ok;
    logic [21:0] held;
    bit  inject_enable = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_prog_seq #(.STARTUP_CYCLES(STARTUP), .REF_DIV(REF_D), .FB_DIV(FB_D)) uut (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_start(xfer_start),
        .xfer_framed(xfer_framed), .xfer_len(xfer_len), .xfer_data(xfer_data),
        .seq_done(seq_done)
    );

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: loads the expected word list into the scoreboard
    task automatic load_expected();
        exp_q.delete();
        exp_q.push_back({1'b0, 5'd4,  16'd0});
        exp_q.push_back({1'b1, 5'd5,  16'd2});
        exp_q.push_back({1'b1, 5'd8,  16'd0});
        exp_q.push_back({1'b1, 5'd15, 16'(REF_D)});
        exp_q.push_back({1'b1, 5'd16, 16'(FB_D)});
    endtask

    // monitor + transmitter model
    initial begin
        forever begin
            @(negedge clk);
            xfer_done = 1'b0;
            if (!rst_n) begin
                words_seen = 0; done_count = 0; last_done_cyc = 0;
                countdown = 0; outstanding = 0;
            end else begin
                if (cyc == 50) xfer_done = 1'b1;   // stray acknowledge in power-up, R10
                if (outstanding && {xfer_framed, xfer_len, xfer_data} !== held) held_ok = 0;
                if (countdown > 0) begin
                    countdown--;
                    if (countdown == 0) begin
                        check(held_ok, "R9", {xfer_framed, xfer_len, xfer_data}, held);
                        xfer_done = 1'b1;
                        outstanding = 0;
                        done_count++;
                        last_done_cyc = cyc;
                    end
                end
                if (xfer_start) begin
                    check(!outstanding, "R10", 1, 0);
                    if (words_seen == 0)
                        check(cyc == STARTUP + 1, "R2", cyc, STARTUP + 1);
                    else
                        check(cyc == last_done_cyc + 1, "R8", cyc, last_done_cyc + 1);
                    if (exp_q.size() == 0) begin
                        check(0, "R11", 1, 0);
                    end else begin
                        logic [21:0] e;
                        e = exp_q.pop_front();
                        check({xfer_framed, xfer_len, xfer_data} === e, req_tab[words_seen],
                              {xfer_framed, xfer_len, xfer_data}, e);
                        held = e;
                        held_ok = 1;
                        outstanding = 1;
                        countdown = lat_tab[words_seen];
                        if (words_seen == 2 && inject_enable) xfer_done = 1'b1; // same-cycle ack, R10
                        words_seen++;
                    end
                end
                if (seq_done !== (done_count == 5 && cyc > last_done_cyc))
                    check(0, "R11", seq_done, done_count == 5);
            end
        end
    end

    task automatic reset_and_check();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(xfer_start == 1'b0 && seq_done == 1'b0, "R1", {xfer_start, seq_done}, 0);
    endtask

    task automatic finish_run(input string tag);
        while (!seq_done) @(negedge clk);
        repeat (40) @(negedge clk);
        check(words_seen == 5, "R11", words_seen, 5);
        check(seq_done == 1'b1, "R11", seq_done, 1);
        check(xfer_start == 1'b0, tag, xfer_start, 0);
    endtask

    initial begin
        // first full run
        load_expected();
        reset_and_check();
        rst_n = 1'b1;
        finish_run("R11");

        // second run, interrupted by a reset after two words
        inject_enable = 1'b0;
        load_expected();
        reset_and_check();
        rst_n = 1'b1;
        while (done_count < 2) @(negedge clk);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(xfer_start == 1'b0 && seq_done == 1'b0, "R12", {xfer_start, seq_done}, 0);
        load_expected();
        @(negedge clk);
        rst_n = 1'b1;
        finish_run("R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule